// File: doc/BRIEF.md
# Parallel NOR Flash Byte Cycle Engine

This block runs single-byte read and write transfers on an asynchronous parallel NOR flash. The flash has a 24-bit address bus and an 8-bit data bus, and the block is clocked at 50 MHz. A host offers a request on a valid/ready handshake. The request carries an address, a direction bit and a write byte. The block then drives the flash pins through a fixed sequence of phases and pulses `done` when the transfer has finished. After a read, it also returns the captured byte.

The flash strobes are packed into a 3-bit control word:

| Bit | Meaning |
| --- | --- |
| 0 | Flash output enable. 1 means the flash drives the data bus. |
| 1 | Chip enable, active low. |
| 2 | Write enable, active low. |

The direction of the data bus on the FPGA side is a separate pin, `fl_dq_oe`.

Each transfer has the following phases, in order:

1. **Setup**: one clock. The address is presented and the control word is still idle.
2. **Access**: a counted run of clocks during which the strobes are held.
3. **Recovery**: one clock. The strobes are back at idle.
4. **Done**: `done` is pulsed for one clock.

The hold counts are derived from the clock period and from the flash timing limits: 75 ns access time for a read and 60 ns write setup time. All three are parameters, so the block can be used at other clock rates. With the defaults, a read holds its strobes for 4 clocks and a write for 3 clocks.

Back-pressure rules on the request side:
- `req_ready` equals the inverse of `busy`.
- A request is taken only on a clock edge where `req_valid` and `req_ready` are both high.
- While a transfer is in flight, `req_valid` is ignored and is not queued.
- The host must keep its request fields stable while `req_valid` is high and `req_ready` is low.

Top module: `flash_bus_engine`

## Requirements
- R1: After reset, `fl_ctrl` is 3'b110, `fl_dq_oe` is 0, `busy` is 0, `done` is 0, `req_ready` is 1 and `rd_data` is 0. A reset asserted in the middle of a transfer returns the pins to this state.
- R2: `req_ready` is always the inverse of `busy`. On the accepting clock edge, `fl_addr` takes the request address. For one clock after that edge, `fl_ctrl` stays at 3'b110 (the setup clock).
- R3: A read (`req_write`=0) drives `fl_ctrl` = 3'b101 with `fl_dq_oe`=0 for exactly READ_HOLD consecutive clocks. READ_HOLD is ceil(READ_ACCESS_PS / CLK_PERIOD_PS), which is 4 with the defaults.
- R4: A write (`req_write`=1) drives `fl_ctrl` = 3'b000 for exactly WRITE_HOLD consecutive clocks. WRITE_HOLD is ceil(WRITE_SETUP_PS / CLK_PERIOD_PS), which is 3 with the defaults. During exactly those clocks, `fl_dq_oe` is 1 and `fl_dq_out` carries the write byte, starting in the clock where write enable falls.
- R5: Outside the access phase, `fl_ctrl` is 3'b110 and `fl_dq_oe` is 0. No other control pattern ever appears.
- R6: `rd_data` takes `fl_dq_in` as sampled at the clock edge that ends the last access clock of a read. It keeps that value through writes and idle time, until the next read.
- R7: `done` is high for exactly one clock. That clock immediately follows the first clock with `fl_ctrl` back at idle. This is the 6th clock edge after acceptance for a read and the 5th for a write.
- R8: A request raised while `busy` is high is ignored. It does not change `fl_addr` or the control sequence, and it does not start a transfer after the current one.
- R9: `busy` rises on the accepting clock edge and falls on the edge that raises `done`. `done` is never high together with `busy`.
- R10: `fl_addr` is stable from the clock after acceptance until `busy` falls.

## Ports
| Port | Direction | Width | Description |
| --- | --- | --- | --- |
| clk | input | 1 | 50 MHz clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Engine can accept a request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 24 | Byte address |
| req_wdata | input | 8 | Byte to write |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | One-clock completion pulse |
| rd_data | output | 8 | Last byte read |
| fl_addr | output | 24 | Flash address lines |
| fl_ctrl | output | 3 | Packed strobes: bit 0 = flash output enable, bit 1 = chip enable (active low), bit 2 = write enable (active low) |
| fl_dq_out | output | 8 | Data driven toward the flash |
| fl_dq_oe | output | 1 | 1 = FPGA drives the data bus |
| fl_dq_in | input | 8 | Data bus as seen from the flash |

## Verification
Call the accepting edge E0. After E0, results come due as follows:

- **Address:** `fl_addr` holds the request address from E0 onward.
- **Strobes:** they appear from E1 and hold for the strobe count (4 clocks for a read, 3 for a write).
- **Idle and capture:** at E(H+1), the control word returns to idle and the read byte is captured.
- **Done:** `done` and the fall of `busy` come at E(H+2).
- **End of pulse:** `done` drops at E(H+3).

The bench samples on the falling edge after each of these edges and checks the expected value for that exact offset. It drives `fl_dq_in` with a junk byte until the last access clock and presents the real byte only then. A capture one clock early, or a strobe run that is one clock short, therefore returns the wrong byte or the wrong pattern. A second request is raised during the busy window, and the bench checks that the address and sequence stay undisturbed.

// File: rtl/flash_bus_pkg.sv
package flash_bus_pkg;

  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_SETUP  = 2'd1,
    ST_ACCESS = 2'd2,
    ST_FINISH = 2'd3
  } fbe_state_e;

  typedef logic [2:0] fl_ctrl_t;

  // Bit positions in the packed strobe word.
  localparam int CTRL_OE_BIT   = 0;
  localparam int CTRL_CE_N_BIT = 1;
  localparam int CTRL_WE_N_BIT = 2;

  localparam fl_ctrl_t CTRL_IDLE  = 3'b110;
  localparam fl_ctrl_t CTRL_READ  = 3'b101;
  localparam fl_ctrl_t CTRL_WRITE = 3'b000;

  // Ceiling division used to turn picosecond limits into clock counts.
  function automatic int ceil_div(input int num, input int den);
    return (num + den - 1) / den;
  endfunction

  function automatic fl_ctrl_t strobe_word(input logic is_write);
    return is_write ? CTRL_WRITE : CTRL_READ;
  endfunction

endpackage

// File: rtl/fbe_hold_timer.sv
module fbe_hold_timer #(
  parameter int CNT_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic             last
);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (load) begin
      cnt_q <= load_val;
    end else if (cnt_q != '0) begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  assign last = (cnt_q == '0);

endmodule

// File: rtl/fbe_sequencer.sv
module fbe_sequencer
  import flash_bus_pkg::*;
#(
  parameter int READ_HOLD  = 4,
  parameter int WRITE_HOLD = 3,
  parameter int CNT_W      = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  input  logic             req_write,
  input  logic             timer_last,
  output logic             accept,
  output logic             enter_access,
  output logic             leave_access,
  output logic             timer_load,
  output logic [CNT_W-1:0] timer_val,
  output logic             cur_write,
  output logic             busy,
  output logic             done
);

  localparam logic [CNT_W-1:0] READ_LOAD  = CNT_W'(READ_HOLD - 1);
  localparam logic [CNT_W-1:0] WRITE_LOAD = CNT_W'(WRITE_HOLD - 1);

  fbe_state_e state_q, state_d;
  logic       write_q;
  logic       done_q;

  assign accept       = (state_q == ST_IDLE) && req_valid;
  assign enter_access = (state_q == ST_SETUP);
  assign leave_access = (state_q == ST_ACCESS) && timer_last;
  assign timer_load   = enter_access;
  assign timer_val    = write_q ? WRITE_LOAD : READ_LOAD;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:   if (req_valid) state_d = ST_SETUP;
      ST_SETUP:  state_d = ST_ACCESS;
      ST_ACCESS: if (timer_last) state_d = ST_FINISH;
      ST_FINISH: state_d = ST_IDLE;
      default:   state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      write_q <= 1'b0;
      done_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      done_q  <= (state_q == ST_FINISH);
      if (accept) write_q <= req_write;
    end
  end

  assign cur_write = write_q;
  assign busy      = (state_q != ST_IDLE);
  assign done      = done_q;

endmodule

// File: rtl/fbe_pin_driver.sv
module fbe_pin_driver
  import flash_bus_pkg::*;
#(
  parameter int ADDR_W = 24,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              accept,
  input  logic              enter_access,
  input  logic              leave_access,
  input  logic              cur_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  input  logic [DATA_W-1:0] fl_dq_in,
  output logic [ADDR_W-1:0] fl_addr,
  output logic [2:0]        fl_ctrl,
  output logic [DATA_W-1:0] fl_dq_out,
  output logic              fl_dq_oe,
  output logic [DATA_W-1:0] rd_data
);

  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] wdata_q;
  logic [DATA_W-1:0] dq_out_q;
  logic [DATA_W-1:0] rd_q;
  fl_ctrl_t          ctrl_q;
  logic              oe_q;

  // Address and write byte are latched on acceptance and held to the end.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q  <= '0;
      wdata_q <= '0;
    end else if (accept) begin
      addr_q  <= req_addr;
      wdata_q <= req_wdata;
    end
  end

  // Strobes and bus direction switch together at both ends of the access.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q   <= CTRL_IDLE;
      oe_q     <= 1'b0;
      dq_out_q <= '0;
    end else if (enter_access) begin
      ctrl_q   <= strobe_word(cur_write);
      oe_q     <= cur_write;
      dq_out_q <= wdata_q;
    end else if (leave_access) begin
      ctrl_q   <= CTRL_IDLE;
      oe_q     <= 1'b0;
    end
  end

  // Read byte captured at the edge that closes the last access clock.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_q <= '0;
    end else if (leave_access && !cur_write) begin
      rd_q <= fl_dq_in;
    end
  end

  assign fl_addr   = addr_q;
  assign fl_ctrl   = ctrl_q;
  assign fl_dq_out = dq_out_q;
  assign fl_dq_oe  = oe_q;
  assign rd_data   = rd_q;

endmodule

// File: rtl/flash_bus_engine.sv
module flash_bus_engine
  import flash_bus_pkg::*;
#(
  parameter int ADDR_W         = 24,
  parameter int DATA_W         = 8,
  parameter int CLK_PERIOD_PS  = 20000,
  parameter int READ_ACCESS_PS = 75000,
  parameter int WRITE_SETUP_PS = 60000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              busy,
  output logic              done,
  output logic [DATA_W-1:0] rd_data,
  output logic [ADDR_W-1:0] fl_addr,
  output logic [2:0]        fl_ctrl,
  output logic [DATA_W-1:0] fl_dq_out,
  output logic              fl_dq_oe,
  input  logic [DATA_W-1:0] fl_dq_in
);

  localparam int READ_HOLD  = (ceil_div(READ_ACCESS_PS, CLK_PERIOD_PS) < 1) ? 1
                              : ceil_div(READ_ACCESS_PS, CLK_PERIOD_PS);
  localparam int WRITE_HOLD = (ceil_div(WRITE_SETUP_PS, CLK_PERIOD_PS) < 1) ? 1
                              : ceil_div(WRITE_SETUP_PS, CLK_PERIOD_PS);
  localparam int MAX_HOLD   = (READ_HOLD > WRITE_HOLD) ? READ_HOLD : WRITE_HOLD;
  localparam int CNT_W      = (MAX_HOLD < 2) ? 1 : $clog2(MAX_HOLD);

  logic             accept;
  logic             enter_access;
  logic             leave_access;
  logic             timer_load;
  logic [CNT_W-1:0] timer_val;
  logic             timer_last;
  logic             cur_write;
  logic             busy_w;

  fbe_sequencer #(
    .READ_HOLD (READ_HOLD),
    .WRITE_HOLD(WRITE_HOLD),
    .CNT_W     (CNT_W)
  ) u_seq (
    .clk         (clk),
    .rst_n       (rst_n),
    .req_valid   (req_valid),
    .req_write   (req_write),
    .timer_last  (timer_last),
    .accept      (accept),
    .enter_access(enter_access),
    .leave_access(leave_access),
    .timer_load  (timer_load),
    .timer_val   (timer_val),
    .cur_write   (cur_write),
    .busy        (busy_w),
    .done        (done)
  );

  fbe_hold_timer #(
    .CNT_W(CNT_W)
  ) u_timer (
    .clk     (clk),
    .rst_n   (rst_n),
    .load    (timer_load),
    .load_val(timer_val),
    .last    (timer_last)
  );

  fbe_pin_driver #(
    .ADDR_W(ADDR_W),
    .DATA_W(DATA_W)
  ) u_pins (
    .clk         (clk),
    .rst_n       (rst_n),
    .accept      (accept),
    .enter_access(enter_access),
    .leave_access(leave_access),
    .cur_write   (cur_write),
    .req_addr    (req_addr),
    .req_wdata   (req_wdata),
    .fl_dq_in    (fl_dq_in),
    .fl_addr     (fl_addr),
    .fl_ctrl     (fl_ctrl),
    .fl_dq_out   (fl_dq_out),
    .fl_dq_oe    (fl_dq_oe),
    .rd_data     (rd_data)
  );

  assign busy      = busy_w;
  assign req_ready = !busy_w;

endmodule

// File: rtl/flash_bus_engine_chk.sv
module flash_bus_engine_chk #(
  parameter int ADDR_W     = 24,
  parameter int DATA_W     = 8,
  parameter int READ_HOLD  = 4,
  parameter int WRITE_HOLD = 3
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_ready,
  input logic              busy,
  input logic              done,
  input logic [DATA_W-1:0] rd_data,
  input logic [ADDR_W-1:0] fl_addr,
  input logic [2:0]        fl_ctrl,
  input logic              fl_dq_oe
);

  logic [15:0] rd_run_q;
  logic [15:0] wr_run_q;

  // Length of the current run of read or write strobe clocks.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_run_q <= '0;
      wr_run_q <= '0;
    end else begin
      rd_run_q <= (fl_ctrl == 3'b101) ? rd_run_q + 16'd1 : 16'd0;
      wr_run_q <= (fl_ctrl == 3'b000) ? wr_run_q + 16'd1 : 16'd0;
    end
  end

  p_ready_inv_r2: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready == !busy);

  p_read_len_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(fl_ctrl) == 3'b101 && fl_ctrl != 3'b101) |-> rd_run_q == 16'(READ_HOLD));

  p_write_len_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(fl_ctrl) == 3'b000 && fl_ctrl != 3'b000) |-> wr_run_q == 16'(WRITE_HOLD));

  p_oe_with_we_r4: assert property (@(posedge clk) disable iff (!rst_n)
    fl_dq_oe == (fl_ctrl == 3'b000));

  p_legal_ctrl_r5: assert property (@(posedge clk) disable iff (!rst_n)
    fl_ctrl == 3'b110 || fl_ctrl == 3'b101 || fl_ctrl == 3'b000);

  p_idle_pins_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (fl_ctrl == 3'b110 && !fl_dq_oe));

  p_rd_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(fl_ctrl) != 3'b101) |-> $stable(rd_data));

  p_done_single_r7: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  p_done_after_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> ($past(fl_ctrl) == 3'b110 && $past(busy)));

  p_done_not_busy_r9: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);

  p_addr_stable_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> $stable(fl_addr));

endmodule

bind flash_bus_engine flash_bus_engine_chk #(
  .ADDR_W    (ADDR_W),
  .DATA_W    (DATA_W),
  .READ_HOLD (READ_HOLD),
  .WRITE_HOLD(WRITE_HOLD)
) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .req_ready(req_ready),
  .busy     (busy),
  .done     (done),
  .rd_data  (rd_data),
  .fl_addr  (fl_addr),
  .fl_ctrl  (fl_ctrl),
  .fl_dq_oe (fl_dq_oe)
);

// File: tb/flash_bus_engine_tb_top.sv
module flash_bus_engine_tb_top;

  localparam time CLK_PERIOD = 20ns;
  localparam int  RD_HOLD    = 4;
  localparam int  WR_HOLD    = 3;
  localparam int  NVEC       = 6;

  // {write, addr, wdata, flash byte}
  localparam logic [40:0] VEC [0:NVEC-1] = '{
    {1'b0, 24'h000000, 8'h00, 8'h5A},
    {1'b1, 24'hFFFFFF, 8'hC3, 8'h00},
    {1'b0, 24'h123456, 8'h00, 8'hA5},
    {1'b1, 24'h800001, 8'h7E, 8'h00},
    {1'b0, 24'hFFFFFF, 8'h00, 8'hFF},
    {1'b1, 24'h0F0F0F, 8'h00, 8'h00}
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic        req_write = 1'b0;
  logic [23:0] req_addr = '0;
  logic [7:0]  req_wdata = '0;
  logic        busy;
  logic        done;
  logic [7:0]  rd_data;
  logic [23:0] fl_addr;
  logic [2:0]  fl_ctrl;
  logic [7:0]  fl_dq_out;
  logic        fl_dq_oe;
  logic [7:0]  fl_dq_in = 8'hEE;

  int n_tests = 0;
  int n_fail  = 0;
  bit finished = 1'b0;
  logic [7:0] exp_rd = 8'h00;

  always #(CLK_PERIOD/2) clk = ~clk;

  flash_bus_engine dut_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .req_valid(req_valid),
    .req_ready(req_ready),
    .req_write(req_write),
    .req_addr (req_addr),
    .req_wdata(req_wdata),
    .busy     (busy),
    .done     (done),
    .rd_data  (rd_data),
    .fl_addr  (fl_addr),
    .fl_ctrl  (fl_ctrl),
    .fl_dq_out(fl_dq_out),
    .fl_dq_oe (fl_dq_oe),
    .fl_dq_in (fl_dq_in)
  );

  task automatic chk(input string rq, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h at %0t", rq, what, act, exp, $time);
    end
  endtask

  task automatic do_cycle(input logic wr, input logic [23:0] a, input logic [7:0] wd,
                          input logic [7:0] fd, input bit intrude);
    int h;
    h = wr ? WR_HOLD : RD_HOLD;
    @(negedge clk);
    chk("R2", "ready before request", req_ready, 1);
    req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = wd;
    @(posedge clk);
    @(negedge clk);
    // setup clock: address out, strobes idle
    req_valid = intrude;
    req_addr  = ~a; req_wdata = ~wd; req_write = ~wr;
    chk("R2", "setup ctrl", fl_ctrl, 3'b110);
    chk("R2", "setup addr", fl_addr, a);
    chk("R9", "busy after accept", busy, 1);
    chk("R2", "ready low", req_ready, 0);
    for (int k = 1; k <= h; k++) begin
      @(negedge clk);
      if (wr) begin
        chk("R4", "write strobe", fl_ctrl, 3'b000);
        chk("R4", "drive enable", fl_dq_oe, 1);
        chk("R4", "write byte", fl_dq_out, wd);
      end else begin
        chk("R3", "read strobe", fl_ctrl, 3'b101);
        chk("R3", "drive off", fl_dq_oe, 0);
      end
      chk("R10", "addr held", fl_addr, a);
      chk("R7", "no early done", done, 0);
      fl_dq_in = (k == h) ? fd : 8'hEE;
    end
    @(negedge clk);
    req_valid = 1'b0;
    fl_dq_in = 8'hEE;
    if (!wr) exp_rd = fd;
    chk("R5", "idle after access", fl_ctrl, 3'b110);
    chk("R5", "drive off after", fl_dq_oe, 0);
    chk("R9", "busy in recovery", busy, 1);
    chk("R7", "no done in recovery", done, 0);
    chk("R6", "read byte", rd_data, exp_rd);
    chk("R8", "addr not taken", fl_addr, a);
    @(negedge clk);
    chk("R7", "done pulse", done, 1);
    chk("R9", "busy low with done", busy, 0);
    chk("R6", "read byte held", rd_data, exp_rd);
    @(negedge clk);
    chk("R7", "done single", done, 0);
    chk("R8", "no second transfer", busy, 0);
    chk("R8", "ctrl still idle", fl_ctrl, 3'b110);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R1", "reset ctrl", fl_ctrl, 3'b110);
    chk("R1", "reset oe", fl_dq_oe, 0);
    chk("R1", "reset busy", busy, 0);
    chk("R1", "reset done", done, 0);
    chk("R1", "reset ready", req_ready, 1);
    chk("R1", "reset rd_data", rd_data, 0);
    rst_n = 1'b1;
    @(negedge clk);

    for (int i = 0; i < NVEC; i++) begin
      do_cycle(VEC[i][40], VEC[i][39:16], VEC[i][15:8], VEC[i][7:0], 1'b0);
    end

    // R8: request raised during a read and during a write
    do_cycle(1'b0, 24'hABCDEF, 8'h00, 8'h3C, 1'b1);
    do_cycle(1'b1, 24'h000100, 8'h99, 8'h00, 1'b1);

    // R1: reset in the middle of a read strobe
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b0; req_addr = 24'h445566;
    @(negedge clk);
    req_valid = 1'b0;
    @(negedge clk);
    chk("R3", "strobe before reset", fl_ctrl, 3'b101);
    rst_n = 1'b0;
    #1;
    chk("R1", "mid reset ctrl", fl_ctrl, 3'b110);
    chk("R1", "mid reset busy", busy, 0);
    chk("R1", "mid reset rd_data", rd_data, 0);
    @(negedge clk);
    rst_n = 1'b1;
    exp_rd = 8'h00;
    do_cycle(1'b0, 24'h000002, 8'h00, 8'h81, 1'b0);

    finished = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

endmodule